// File: doc/BRIEF.md
# Windowless Watchdog Down-Counter

This block guards a processor against runaway software. A 7-bit counter is decremented once per prescaler period. The prescaler is a counter of machine-cycle strobes with a fixed division ratio. Software must rewrite the control register before the counter's most significant bit drops out. If the watchdog is armed when that bit falls, an active-low reset pulse of fixed length is produced, and the whole block then restarts from its power-on state.

The counter never stops. It keeps counting and wrapping while the watchdog is unarmed, so arming it only decides whether the expiry has an effect. Arming can come from software through the control register, or permanently from a hardware-mode configuration strap. A second strap makes entry into the processor's halt state a reset cause while the watchdog is armed. The control register reads back the arm flag in bit 7 and the count in bits 6:0.

Top module: `wdt_core`

## Requirements
- R1: After power-on reset the readback is 7Fh with bit 7 replaced by `opt_hw_wdg`, and `wdg_rst_n` is high.
- R2: The count drops by one after every PRESC_DIV clock cycles on which `cyc_en` is high. Cycles with `cyc_en` low do not advance the prescaler.
- R3: While unarmed the count keeps decrementing, wraps from 00h to 7Fh, and never causes a reset.
- R4: A write loads bits 6:0 into the count and clears the prescaler. A 1 in bit 7 arms the watchdog. A 0 in bit 7 never disarms it, so only a reset pulse or power-on reset clears the arm flag.
- R5: While armed, the decrement from 40h to 3Fh starts a reset pulse. After a write of C0h+k, `wdg_rst_n` goes low exactly (k+1)*PRESC_DIV enabled cycles later.
- R6: A write in the same cycle as the expiring decrement takes priority: the written value is loaded and no reset follows.
- R7: A write that leaves the watchdog armed with bit 6 = 0 starts a reset pulse in the next cycle. The same write made while unarmed and with bit 7 = 0 only loads the count.
- R8: With `opt_halt_rst` high and the watchdog armed, a cycle of `halt_enter` starts a reset pulse. If either condition is missing, halt entry has no effect.
- R9: With `opt_hw_wdg` high the watchdog is armed at all times, and readback bit 7 is 1 without any software write.
- R10: `wdg_rst_n` stays low for exactly PULSE_LEN cycles. After the pulse the readback is 7Fh with bit 7 equal to `opt_hw_wdg`, and the prescaler restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cyc_en | input | 1 | Machine-cycle strobe that advances the prescaler |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write value: bit 7 arms, bits 6:0 load the count |
| rd_data | output | 8 | Readback: arm flag in bit 7, count in bits 6:0 |
| halt_enter | input | 1 | One-cycle indication that the processor enters halt |
| opt_halt_rst | input | 1 | Configuration: halt entry resets while armed |
| opt_hw_wdg | input | 1 | Configuration: watchdog permanently armed |
| wdg_rst_n | output | 1 | Reset pulse output, active low |

## Verification
A refresh write and the decrement that would expire the count can land in the same clock cycle. The bench writes C0h, waits PRESC_DIV-1 cycles, and issues a second write so that it is sampled on the very edge where the prescaler ends its period with the count at 40h. The check passes only if the reset output stays high, the readback equals the second value, and the next expiry arrives a full (k+1) periods after that write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CNT_W = 7;
  typedef logic [CNT_W-1:0] wdt_cnt_t;

  localparam wdt_cnt_t CNT_INIT   = 7'h7F;
  localparam wdt_cnt_t CNT_EXPIRE = 7'h40;

  // Next count on a prescaler period: plain modulo-128 decrement.
  function automatic wdt_cnt_t wdt_dec(input wdt_cnt_t c);
    return c - wdt_cnt_t'(1);
  endfunction

  // A decrement from this value clears the top count bit.
  function automatic logic wdt_expires(input wdt_cnt_t c);
    return c == CNT_EXPIRE;
  endfunction

  // A written value whose top count bit is clear means an expiry at once.
  function automatic logic wdt_top_clear(input logic [7:0] v);
    return !v[CNT_W-1];
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 49152
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic cyc_en,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = cyc_en && !clr;
    end else begin : g_count
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;
      logic          at_last;

      assign at_last = (pre_q == LAST);
      assign tick    = cyc_en && at_last && !clr;

      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
          pre_q <= '0;
        end else if (clr) begin
          pre_q <= '0;
        end else if (cyc_en) begin
          pre_q <= at_last ? '0 : pre_q + PW'(1);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     por_n,
  input  logic     hold,
  input  logic     load,
  input  wdt_cnt_t load_val,
  input  logic     dec,
  output wdt_cnt_t cnt
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt <= CNT_INIT;
    end else if (hold) begin
      cnt <= CNT_INIT;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec) begin
      cnt <= wdt_dec(cnt);
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       hold,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       tick,
  input  wdt_cnt_t   cnt,
  input  logic       halt_enter,
  input  logic       opt_halt_rst,
  input  logic       opt_hw_wdg,
  output logic       active,
  output logic       fire
);
  logic sw_arm_q;
  logic arm_after_wr;
  logic fire_wr;
  logic fire_cnt;
  logic fire_halt;

  assign active       = sw_arm_q || opt_hw_wdg;
  assign arm_after_wr = active || wr_data[7];

  assign fire_wr   = wr_en && arm_after_wr && wdt_top_clear(wr_data);
  assign fire_cnt  = !wr_en && tick && active && wdt_expires(cnt);
  assign fire_halt = halt_enter && opt_halt_rst && active;
  assign fire      = !hold && (fire_wr || fire_cnt || fire_halt);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sw_arm_q <= 1'b0;
    end else if (hold) begin
      sw_arm_q <= 1'b0;
    end else if (wr_en && wr_data[7]) begin
      sw_arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int unsigned LEN = 64
) (
  input  logic clk,
  input  logic por_n,
  input  logic fire,
  output logic busy
);
  localparam int unsigned LW = $clog2(LEN + 1);
  logic [LW-1:0] left_q;

  assign busy = (left_q != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      left_q <= '0;
    end else if (busy) begin
      left_q <= left_q - LW'(1);
    end else if (fire) begin
      left_q <= LW'(LEN);
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 49152,
  parameter int unsigned PULSE_LEN = 64
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       cyc_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       halt_enter,
  input  logic       opt_halt_rst,
  input  logic       opt_hw_wdg,
  output logic       wdg_rst_n
);
  logic     tick;
  logic     fire;
  logic     busy;
  logic     active;
  logic     wr_live;
  wdt_cnt_t cnt;

  assign wr_live = wr_en && !busy;

  wdt_prescaler #(.DIV(PRESC_DIV)) u_pre (
    .clk    (clk),
    .por_n  (por_n),
    .clr    (wr_live || busy),
    .cyc_en (cyc_en),
    .tick   (tick)
  );

  wdt_counter u_cnt (
    .clk      (clk),
    .por_n    (por_n),
    .hold     (busy),
    .load     (wr_live),
    .load_val (wr_data[CNT_W-1:0]),
    .dec      (tick),
    .cnt      (cnt)
  );

  wdt_ctrl u_ctrl (
    .clk          (clk),
    .por_n        (por_n),
    .hold         (busy),
    .wr_en        (wr_live),
    .wr_data      (wr_data),
    .tick         (tick),
    .cnt          (cnt),
    .halt_enter   (halt_enter),
    .opt_halt_rst (opt_halt_rst),
    .opt_hw_wdg   (opt_hw_wdg),
    .active       (active),
    .fire         (fire)
  );

  wdt_rst_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk   (clk),
    .por_n (por_n),
    .fire  (fire),
    .busy  (busy)
  );

  assign rd_data   = {active, cnt};
  assign wdg_rst_n = !busy;
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
  parameter int unsigned PULSE_LEN = 64
) (
  input logic       clk,
  input logic       por_n,
  input logic       cyc_en,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       halt_enter,
  input logic       opt_halt_rst,
  input logic       tick,
  input logic       fire,
  input logic       busy,
  input logic       active,
  input logic [6:0] cnt,
  input logic       wdg_rst_n
);
  logic [31:0] low_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) low_run <= '0;
    else if (!wdg_rst_n) low_run <= low_run + 32'd1;
    else low_run <= '0;
  end

  // R2
  tick_needs_strobe_chk: assert property (@(posedge clk) disable iff (!por_n)
    tick |-> cyc_en);

  // R2
  dec_on_tick_chk: assert property (@(posedge clk) disable iff (!por_n)
    tick && !wr_en && !busy |=> cnt == 7'($past(cnt) - 7'd1));

  // R4
  write_loads_chk: assert property (@(posedge clk) disable iff (!por_n)
    wr_en && !busy |=> cnt == $past(wr_data[6:0]));

  // R4
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(active) |-> $past(busy));

  // R5
  expiry_fires_chk: assert property (@(posedge clk) disable iff (!por_n)
    active && tick && !wr_en && !busy && cnt == 7'h40 |=> !wdg_rst_n);

  // R6
  refresh_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
    wr_en && !busy && wr_data[6] && !(halt_enter && opt_halt_rst) |=> wdg_rst_n);

  // R7
  bad_write_fires_chk: assert property (@(posedge clk) disable iff (!por_n)
    wr_en && !busy && (active || wr_data[7]) && !wr_data[6] |=> !wdg_rst_n);

  // R8
  halt_fires_chk: assert property (@(posedge clk) disable iff (!por_n)
    halt_enter && opt_halt_rst && active && !busy |=> !wdg_rst_n);

  // R10
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(wdg_rst_n) |-> $past(fire));

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wdg_rst_n) |-> low_run == PULSE_LEN);

  // R10
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!por_n)
    low_run <= PULSE_LEN);
endmodule

bind wdt_core wdt_core_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .cyc_en       (cyc_en),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .halt_enter   (halt_enter),
  .opt_halt_rst (opt_halt_rst),
  .tick         (tick),
  .fire         (fire),
  .busy         (busy),
  .active       (active),
  .cnt          (cnt),
  .wdg_rst_n    (wdg_rst_n)
);

// File: tb/wdt_core_tb.sv
`timescale 1ns/1ps
module wdt_core_tb;
  localparam int P = 4;
  localparam int L = 8;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       cyc_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       halt_enter = 1'b0;
  logic       opt_halt_rst = 1'b0;
  logic       opt_hw_wdg = 1'b0;
  logic       wdg_rst_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdt_core #(.PRESC_DIV(P), .PULSE_LEN(L)) u_dut (
    .clk(clk), .por_n(por_n), .cyc_en(cyc_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .halt_enter(halt_enter),
    .opt_halt_rst(opt_halt_rst), .opt_hw_wdg(opt_hw_wdg),
    .wdg_rst_n(wdg_rst_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_por();
    por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rst(output int n);
    n = 0;
    while (wdg_rst_n && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure_low(output int m);
    m = 0;
    while (!wdg_rst_n && m < 5000) begin
      m++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_por();
    chk(rd_data == 8'h7F, "R1 readback", rd_data, 8'h7F);
    chk(wdg_rst_n == 1'b1, "R1 reset output", wdg_rst_n, 1);
  endtask

  task automatic t_prescale();
    wr(8'h7F);
    cyc_en = 1'b0;
    repeat (3 * P) @(negedge clk);
    chk(rd_data == 8'h7F, "R2 stalled without strobe", rd_data, 8'h7F);
    cyc_en = 1'b1;
    repeat (P) @(negedge clk);
    chk(rd_data == 8'h7E, "R2 one period", rd_data, 8'h7E);
  endtask

  task automatic t_freerun();
    bit low_seen = 1'b0;
    wr(8'h7F);
    repeat (5 * P) @(negedge clk);
    chk(rd_data == 8'h7A, "R3 decrement unarmed", rd_data, 8'h7A);
    for (int i = 0; i < 123 * P; i++) begin
      @(negedge clk);
      if (!wdg_rst_n) low_seen = 1'b1;
    end
    chk(rd_data == 8'h7F, "R3 wrap to 7F", rd_data, 8'h7F);
    chk(!low_seen, "R3 no reset unarmed", low_seen, 0);
  endtask

  task automatic t_sticky_timeout();
    int n, m;
    wr(8'hC5);
    chk(rd_data == 8'hC5, "R4 arm write", rd_data, 8'hC5);
    wr(8'h45);
    chk(rd_data == 8'hC5, "R4 bit7 zero ignored", rd_data, 8'hC5);
    wait_rst(n);
    chk(n == 6 * P, "R5 timeout k=5", n, 6 * P);
    measure_low(m);
    chk(m == L, "R10 pulse width", m, L);
    chk(rd_data == 8'h7F, "R10 state after pulse", rd_data, 8'h7F);
  endtask

  task automatic t_timeout_edges();
    int n, m;
    wr(8'hC0);
    wait_rst(n);
    chk(n == P, "R5 timeout k=0", n, P);
    measure_low(m);
    wr(8'hFF);
    wait_rst(n);
    chk(n == 64 * P, "R5 timeout k=63", n, 64 * P);
    measure_low(m);
    chk(m == L, "R10 pulse width again", m, L);
  endtask

  task automatic t_collide();
    int n, m;
    wr(8'hC0);
    repeat (P - 1) @(negedge clk);
    wr(8'hC3);
    chk(wdg_rst_n == 1'b1, "R6 refresh on expiry edge", wdg_rst_n, 1);
    chk(rd_data == 8'hC3, "R6 written value kept", rd_data, 8'hC3);
    wait_rst(n);
    chk(n == 4 * P, "R6 next expiry", n, 4 * P);
    measure_low(m);
  endtask

  task automatic t_immediate();
    int m;
    wr(8'h30);
    chk(wdg_rst_n == 1'b1, "R7 unarmed low write", wdg_rst_n, 1);
    chk(rd_data == 8'h30, "R7 unarmed load", rd_data, 8'h30);
    wr(8'hC8);
    wr(8'h08);
    chk(wdg_rst_n == 1'b0, "R7 armed low write resets", wdg_rst_n, 0);
    measure_low(m);
    chk(m == L, "R7 pulse width", m, L);
  endtask

  task automatic t_halt();
    int m;
    opt_halt_rst = 1'b1;
    halt_enter = 1'b1;
    @(negedge clk);
    halt_enter = 1'b0;
    chk(wdg_rst_n == 1'b1, "R8 halt unarmed", wdg_rst_n, 1);
    wr(8'hFF);
    opt_halt_rst = 1'b0;
    halt_enter = 1'b1;
    @(negedge clk);
    halt_enter = 1'b0;
    chk(wdg_rst_n == 1'b1, "R8 halt option off", wdg_rst_n, 1);
    opt_halt_rst = 1'b1;
    halt_enter = 1'b1;
    @(negedge clk);
    halt_enter = 1'b0;
    chk(wdg_rst_n == 1'b0, "R8 halt resets", wdg_rst_n, 0);
    measure_low(m);
    opt_halt_rst = 1'b0;
  endtask

  task automatic t_hw();
    int n, m;
    opt_hw_wdg = 1'b1;
    #1;
    chk(rd_data[7] == 1'b1, "R9 armed by strap", rd_data[7], 1);
    do_por();
    chk(rd_data == 8'hFF, "R1 reset with strap", rd_data, 8'hFF);
    wr(8'h7F);
    wait_rst(n);
    chk(n == 64 * P, "R9 hardware timeout", n, 64 * P);
    measure_low(m);
    chk(rd_data == 8'hFF, "R10 strap survives pulse", rd_data, 8'hFF);
    opt_hw_wdg = 1'b0;
    do_por();
  endtask

  initial begin
    t_reset();
    t_prescale();
    t_freerun();
    t_sticky_timeout();
    t_timeout_edges();
    t_collide();
    t_immediate();
    t_halt();
    t_hw();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL run hung: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule